// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a freshly reset SDRAM through its start-up sequence on the command pins, then raises a done flag so that the normal memory controller can take over. It first waits a long stretch of stable clock with clock-enable and the data masks held high, driving only no-operation commands. It then closes every bank with a precharge-all and runs a programmable number of auto-refresh cycles. A mode register set loads the operating mode word, carried on the low address bits. A parameter chooses whether the refreshes come before or after the mode register set. Every command takes exactly one cycle and is followed by no-operation cycles that cover the timing the memory needs.

The stable-power hold is given in nanoseconds and converted to cycles from the clock period, rounding up. The post-precharge wait, the refresh cycle time, the mode-set gap and the refresh count are parameters. Values below 2 are raised to 2, so every command has at least one no-operation cycle after it. Timing below counts rising edges after the cycle in which `rst` is sampled low. Cycle k is the output seen after k such edges. S is the hold length in cycles, P the post-precharge wait, C the refresh cycle time, M the mode-set gap and N the refresh count.

Top module: `sdram_boot_seq`

## Requirements
- R1: `sdr_cke` and every bit of `sdr_dqm` are 1 in every cycle, during reset and after it.
- R2: Reset puts a no-operation on the pins (`sdr_cs_n`=0, `sdr_ras_n`=1, `sdr_cas_n`=1, `sdr_we_n`=1) with `init_done`=0. Cycles 0 to S-1 carry only no-operations, where S = ceil(STABLE_NS*1000/CLK_PERIOD_PS).
- R3: In cycle S a precharge-all is driven: cs_n=0, ras_n=0, cas_n=1, we_n=0, with address bit 10 high.
- R4: After the precharge-all, the next command comes in cycle S+P, and cycles S+1 to S+P-1 are no-operations.
- R5: Exactly N auto-refresh commands are issued (cs_n=0, ras_n=0, cas_n=0, we_n=1). If the first one is in cycle F, refresh i is in cycle F+i*C, with only no-operations between them.
- R6: The mode register set is driven with cs_n, ras_n, cas_n and we_n all 0. `sdr_addr[9:0]` carries MODE_WORD, while `sdr_addr[10]` and both bank bits are 0.
- R7: After a mode register set in cycle t, cycles t+1 to t+M-1 carry no-operations.
- R8: With MODE_FIRST=0 the refreshes start in cycle S+P and the mode set lands in cycle S+P+N*C. With MODE_FIRST=1 the mode set is in cycle S+P and the refreshes start in cycle S+P+M.
- R9: `init_done` first goes high in cycle S+P+N*C+M, for either order. After that it stays high and only no-operations are driven until the next reset.
- R10: Asserting `rst` at any point of the sequence returns the block to the R2 state, and the whole sequence then restarts from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdr_cke | output | 1 | Clock enable to the memory |
| sdr_dqm | output | DQM_W | Data masks, all high |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_ba | output | BA_W | Bank address, 0 throughout |
| sdr_addr | output | ADDR_W | Address bus: bit 10 for precharge-all, mode word for mode set |
| init_done | output | 1 | High once the sequence has finished |

## Verification
The pins and `init_done` are decoded straight from the step register, so each result is due in the same cycle the sequence reaches it, with no extra pipeline stage. The bench counts edges after reset release and samples on the falling edge that follows each rising edge. It compares every cycle against a schedule built from S, P, C, M and N, so a command one cycle early or late fails at the cycle where it appears. Two instances cover both orders, with different timings and a hold length that needs rounding up. Random reset lengths and random points of abort check that the sequence restarts and that the done flag stays high once set.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_PRE,
        ST_PRE_GAP,
        ST_REF,
        ST_REF_GAP,
        ST_MRS,
        ST_MRS_GAP,
        ST_DONE
    } step_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    function automatic pins_t cmd_pins(cmd_e c);
        pins_t p;
        case (c)
            CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

    function automatic int unsigned at_least(int unsigned v, int unsigned lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned ceil_div(longint unsigned num, longint unsigned den);
        return int'((num + den - 1) / den);
    endfunction

endpackage

// File: rtl/boot_step_timer.sv
module boot_step_timer #(
    parameter int unsigned W         = 16,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/boot_step_fsm.sv
module boot_step_fsm
    import sdram_boot_pkg::*;
#(
    parameter int unsigned TW         = 16,
    parameter int unsigned REFS       = 2,
    parameter int unsigned TRP_C      = 2,
    parameter int unsigned TRC_C      = 2,
    parameter int unsigned TMRS_C     = 2,
    parameter bit          MODE_FIRST = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          expired,
    output step_e         step,
    output logic          timer_load,
    output logic [TW-1:0] timer_val
);
    localparam int unsigned RCW = $clog2(REFS + 1);

    step_e          step_q, step_d;
    logic [RCW-1:0] refs_q;
    logic           refs_all;

    assign refs_all = (refs_q == RCW'(REFS));

    // The order parameter picks which step follows the post-precharge gap
    // and where each later gap leads.
    step_e after_pre, after_refs, after_mrs;
    generate
        if (MODE_FIRST) begin : g_mode_first
            assign after_pre  = ST_MRS;
            assign after_mrs  = ST_REF;
            assign after_refs = ST_DONE;
        end else begin : g_refresh_first
            assign after_pre  = ST_REF;
            assign after_refs = ST_MRS;
            assign after_mrs  = ST_DONE;
        end
    endgenerate

    always_comb begin
        step_d     = step_q;
        timer_load = 1'b0;
        timer_val  = '0;
        case (step_q)
            ST_HOLD:    if (expired) step_d = ST_PRE;
            ST_PRE: begin
                timer_load = 1'b1;
                timer_val  = TW'(TRP_C - 2);
                step_d     = ST_PRE_GAP;
            end
            ST_PRE_GAP: if (expired) step_d = after_pre;
            ST_REF: begin
                timer_load = 1'b1;
                timer_val  = TW'(TRC_C - 2);
                step_d     = ST_REF_GAP;
            end
            ST_REF_GAP: if (expired) step_d = refs_all ? after_refs : ST_REF;
            ST_MRS: begin
                timer_load = 1'b1;
                timer_val  = TW'(TMRS_C - 2);
                step_d     = ST_MRS_GAP;
            end
            ST_MRS_GAP: if (expired) step_d = after_mrs;
            default:    step_d = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_HOLD;
            refs_q <= '0;
        end else begin
            step_q <= step_d;
            if (step_q == ST_REF) refs_q <= refs_q + 1'b1;
        end
    end

    assign step = step_q;
endmodule

// File: rtl/boot_cmd_encode.sv
module boot_cmd_encode
    import sdram_boot_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 11,
    parameter int unsigned     BA_W      = 2,
    parameter int unsigned     AP_BIT    = 10,
    parameter logic [AP_BIT-1:0] MODE_WORD = '0
) (
    input  step_e             step,
    output pins_t             pins,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              done
);
    cmd_e cmd;

    always_comb begin
        case (step)
            ST_PRE:  cmd = CMD_PRE;
            ST_REF:  cmd = CMD_REF;
            ST_MRS:  cmd = CMD_MRS;
            default: cmd = CMD_NOP;
        endcase
    end

    always_comb begin
        addr = '0;
        case (cmd)
            CMD_PRE: addr[AP_BIT] = 1'b1;
            CMD_MRS: addr[AP_BIT-1:0] = MODE_WORD;
            default: addr = '0;
        endcase
    end

    assign pins = cmd_pins(cmd);
    assign ba   = '0;
    assign done = (step == ST_DONE);
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int unsigned       CLK_PERIOD_PS = 4000,
    parameter int unsigned       STABLE_NS     = 200000,
    parameter int unsigned       TRP_CYC       = 3,
    parameter int unsigned       TRC_CYC       = 9,
    parameter int unsigned       TMRS_CYC      = 2,
    parameter int unsigned       REFRESH_COUNT = 2,
    parameter bit                MODE_FIRST    = 1'b0,
    parameter int unsigned       ADDR_W        = 11,
    parameter int unsigned       AP_BIT        = 10,
    parameter int unsigned       BA_W          = 2,
    parameter int unsigned       DQM_W         = 4,
    parameter logic [AP_BIT-1:0] MODE_WORD     = 10'h032
) (
    input  logic              clk,
    input  logic              rst,
    output logic              sdr_cke,
    output logic [DQM_W-1:0]  sdr_dqm,
    output logic              sdr_cs_n,
    output logic              sdr_ras_n,
    output logic              sdr_cas_n,
    output logic              sdr_we_n,
    output logic [BA_W-1:0]   sdr_ba,
    output logic [ADDR_W-1:0] sdr_addr,
    output logic              init_done
);
    localparam int unsigned STABLE_CYC = at_least(ceil_div(longint'(STABLE_NS) * 1000, CLK_PERIOD_PS), 1);
    localparam int unsigned TRP_C      = at_least(TRP_CYC, 2);
    localparam int unsigned TRC_C      = at_least(TRC_CYC, 2);
    localparam int unsigned TMRS_C     = at_least(TMRS_CYC, 2);
    localparam int unsigned REFS       = at_least(REFRESH_COUNT, 2);
    localparam int unsigned LONGEST    = max2(max2(STABLE_CYC, TRP_C), max2(TRC_C, TMRS_C));
    localparam int unsigned TW         = $clog2(LONGEST + 1);

    step_e         step;
    logic          timer_load;
    logic [TW-1:0] timer_val;
    logic          expired;
    pins_t         pins;

    boot_step_timer #(
        .W        (TW),
        .RESET_VAL(STABLE_CYC - 1)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .load_val(timer_val),
        .expired (expired)
    );

    boot_step_fsm #(
        .TW        (TW),
        .REFS      (REFS),
        .TRP_C     (TRP_C),
        .TRC_C     (TRC_C),
        .TMRS_C    (TMRS_C),
        .MODE_FIRST(MODE_FIRST)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .expired   (expired),
        .step      (step),
        .timer_load(timer_load),
        .timer_val (timer_val)
    );

    boot_cmd_encode #(
        .ADDR_W   (ADDR_W),
        .BA_W     (BA_W),
        .AP_BIT   (AP_BIT),
        .MODE_WORD(MODE_WORD)
    ) u_enc (
        .step(step),
        .pins(pins),
        .addr(sdr_addr),
        .ba  (sdr_ba),
        .done(init_done)
    );

    assign sdr_cke   = 1'b1;
    assign sdr_dqm   = '1;
    assign sdr_cs_n  = pins.cs_n;
    assign sdr_ras_n = pins.ras_n;
    assign sdr_cas_n = pins.cas_n;
    assign sdr_we_n  = pins.we_n;
endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk #(
    parameter int unsigned ADDR_W        = 11,
    parameter int unsigned AP_BIT        = 10,
    parameter int unsigned BA_W          = 2,
    parameter int unsigned DQM_W         = 4,
    parameter int unsigned TMRS_CYC      = 2,
    parameter int unsigned REFRESH_COUNT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sdr_cke,
    input logic [DQM_W-1:0]  sdr_dqm,
    input logic              sdr_cs_n,
    input logic              sdr_ras_n,
    input logic              sdr_cas_n,
    input logic              sdr_we_n,
    input logic [BA_W-1:0]   sdr_ba,
    input logic [ADDR_W-1:0] sdr_addr,
    input logic              init_done
);
    localparam int unsigned TM   = (TMRS_CYC < 2) ? 2 : TMRS_CYC;
    localparam int unsigned NREF = (REFRESH_COUNT < 2) ? 2 : REFRESH_COUNT;

    logic is_nop, is_pre, is_ref, is_mrs;
    assign is_nop = !sdr_cs_n &&  sdr_ras_n &&  sdr_cas_n &&  sdr_we_n;
    assign is_pre = !sdr_cs_n && !sdr_ras_n &&  sdr_cas_n && !sdr_we_n;
    assign is_ref = !sdr_cs_n && !sdr_ras_n && !sdr_cas_n &&  sdr_we_n;
    assign is_mrs = !sdr_cs_n && !sdr_ras_n && !sdr_cas_n && !sdr_we_n;

    logic [31:0] mrs_age;
    logic [31:0] ref_seen;
    logic        mrs_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            mrs_age  <= '0;
            ref_seen <= '0;
            mrs_seen <= 1'b0;
        end else begin
            if (is_mrs) begin
                mrs_age  <= 32'd1;
                mrs_seen <= 1'b1;
            end else if (mrs_age != 0 && mrs_age < TM) begin
                mrs_age <= mrs_age + 1;
            end
            if (is_ref) ref_seen <= ref_seen + 1;
        end
    end

    assert_pins_high_R1: assert property (@(posedge clk) disable iff (rst)
        sdr_cke && (&sdr_dqm));
    assert_legal_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        is_nop || is_pre || is_ref || is_mrs);
    assert_pre_all_R3: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> sdr_addr[AP_BIT]);
    assert_gap_after_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        !is_nop |=> is_nop);
    assert_ref_total_R5: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (ref_seen == NREF));
    assert_mrs_fields_R6: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (sdr_ba == '0 && sdr_addr[ADDR_W-1:AP_BIT] == '0));
    assert_mrs_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (mrs_age != 0 && mrs_age < TM) |-> is_nop);
    assert_done_after_mrs_R7: assert property (@(posedge clk) disable iff (rst)
        init_done |-> mrs_seen);
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        init_done |-> is_nop);
endmodule

bind sdram_boot_seq sdram_boot_chk #(
    .ADDR_W       (ADDR_W),
    .AP_BIT       (AP_BIT),
    .BA_W         (BA_W),
    .DQM_W        (DQM_W),
    .TMRS_CYC     (TMRS_CYC),
    .REFRESH_COUNT(REFRESH_COUNT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sdr_cke  (sdr_cke),
    .sdr_dqm  (sdr_dqm),
    .sdr_cs_n (sdr_cs_n),
    .sdr_ras_n(sdr_ras_n),
    .sdr_cas_n(sdr_cas_n),
    .sdr_we_n (sdr_we_n),
    .sdr_ba   (sdr_ba),
    .sdr_addr (sdr_addr),
    .init_done(init_done)
);

// File: tb/sdram_boot_seq_tb.sv
`timescale 1ns/1ps
module sdram_boot_seq_tb;
    // Instance A: refreshes first, hold 400 ns -> 100 cycles
    localparam int A_S = 100, A_P = 3, A_C = 9, A_M = 2, A_N = 3;
    localparam logic [9:0] A_MODE = 10'h032;
    // Instance B: mode set first, hold 301 ns -> ceil(75.25) = 76 cycles
    localparam int B_S = 76, B_P = 2, B_C = 4, B_M = 3, B_N = 2;
    localparam logic [9:0] B_MODE = 10'h223;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [3:0]  a_dqm;
    logic [1:0]  a_ba;
    logic [10:0] a_addr;
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [3:0]  b_dqm;
    logic [1:0]  b_ba;
    logic [10:0] b_addr;

    sdram_boot_seq #(
        .CLK_PERIOD_PS(4000), .STABLE_NS(400), .TRP_CYC(A_P), .TRC_CYC(A_C),
        .TMRS_CYC(A_M), .REFRESH_COUNT(A_N), .MODE_FIRST(1'b0), .MODE_WORD(A_MODE)
    ) u_dut (
        .clk(clk), .rst(rst), .sdr_cke(a_cke), .sdr_dqm(a_dqm), .sdr_cs_n(a_cs),
        .sdr_ras_n(a_ras), .sdr_cas_n(a_cas), .sdr_we_n(a_we), .sdr_ba(a_ba),
        .sdr_addr(a_addr), .init_done(a_done)
    );

    sdram_boot_seq #(
        .CLK_PERIOD_PS(4000), .STABLE_NS(301), .TRP_CYC(B_P), .TRC_CYC(B_C),
        .TMRS_CYC(B_M), .REFRESH_COUNT(B_N), .MODE_FIRST(1'b1), .MODE_WORD(B_MODE)
    ) u_dut_alt (
        .clk(clk), .rst(rst), .sdr_cke(b_cke), .sdr_dqm(b_dqm), .sdr_cs_n(b_cs),
        .sdr_ras_n(b_ras), .sdr_cas_n(b_cas), .sdr_we_n(b_we), .sdr_ba(b_ba),
        .sdr_addr(b_addr), .init_done(b_done)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // 0 NOP, 1 precharge-all, 2 refresh, 3 mode set, 7 illegal
    function automatic int decode(logic cs, logic ras, logic cas, logic we);
        case ({cs, ras, cas, we})
            4'b0111: return 0;
            4'b0010: return 1;
            4'b0001: return 2;
            4'b0000: return 3;
            default: return 7;
        endcase
    endfunction

    function automatic void expect_at(int k, bit mf, int s, int p, int c, int m, int n,
                                      output int cmd, output bit done, output string tag);
        int t = s + p;
        cmd = 0; done = 1'b0; tag = "R2";
        if (k < s) return;
        if (k == s) begin cmd = 1; tag = "R3"; return; end
        if (k < t) begin tag = "R4"; return; end
        if (!mf) begin
            for (int i = 0; i < n; i++) begin
                if (k == t + i * c) begin cmd = 2; tag = "R5"; return; end
            end
            if (k < t + n * c) begin tag = "R5"; return; end
            if (k == t + n * c) begin cmd = 3; tag = "R6 R8"; return; end
            if (k < t + n * c + m) begin tag = "R7"; return; end
        end else begin
            if (k == t) begin cmd = 3; tag = "R6 R8"; return; end
            if (k < t + m) begin tag = "R7"; return; end
            for (int i = 0; i < n; i++) begin
                if (k == t + m + i * c) begin cmd = 2; tag = "R5 R8"; return; end
            end
            if (k < t + m + n * c) begin tag = "R5"; return; end
        end
        done = 1'b1; tag = "R9";
    endfunction

    task automatic check_one(string nm, int k, bit mf, int s, int p, int c, int m, int n,
                             logic [9:0] mode, logic cke, logic [3:0] dqm, logic cs,
                             logic ras, logic cas, logic we, logic [1:0] ba,
                             logic [10:0] addr, logic done);
        int    ecmd, acmd;
        bit    edone, ok;
        string tag;
        expect_at(k, mf, s, p, c, m, n, ecmd, edone, tag);
        acmd = decode(cs, ras, cas, we);
        ok = (acmd == ecmd) && (done == edone);
        if (ecmd == 1) ok = ok && addr[10];
        if (ecmd == 3) ok = ok && (addr == {1'b0, mode}) && (ba == 2'b00);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s cycle %0d: cmd=%0d done=%0b addr=%h ba=%0d expected cmd=%0d done=%0b",
                     tag, nm, k, acmd, done, addr, ba, ecmd, edone);
        end
        checks++;
        if (!(cke && (&dqm))) begin
            fails++;
            $display("FAIL R1 %s cycle %0d: cke=%0b dqm=%h expected cke=1 dqm=f", nm, k, cke, dqm);
        end
    endtask

    task automatic check_cycle(int k);
        check_one("A", k, 1'b0, A_S, A_P, A_C, A_M, A_N, A_MODE,
                  a_cke, a_dqm, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done);
        check_one("B", k, 1'b1, B_S, B_P, B_C, B_M, B_N, B_MODE,
                  b_cke, b_dqm, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done);
    endtask

    // R10: reset held for rlen edges, then the schedule runs up to stop_k
    task automatic do_run(int rlen, int stop_k);
        @(negedge clk);
        rst = 1'b1;
        repeat (rlen) @(posedge clk);
        @(negedge clk);
        checks++;
        if (decode(a_cs, a_ras, a_cas, a_we) != 0 || a_done || decode(b_cs, b_ras, b_cas, b_we) != 0 || b_done) begin
            fails++;
            $display("FAIL R10 reset state: A cmd=%0d done=%0b B cmd=%0d done=%0b expected cmd=0 done=0",
                     decode(a_cs, a_ras, a_cas, a_we), a_done, decode(b_cs, b_ras, b_cas, b_we), b_done);
        end
        rst = 1'b0;
        for (int k = 0; k <= stop_k; k++) begin
            if (k != 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            check_cycle(k);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        // directed: full runs past completion, and aborts at corner cycles
        do_run(1, 200);
        do_run(2, A_S);            // abort right at precharge of A
        do_run(3, B_S + B_P);      // abort at mode set of B
        do_run(1, 200);
        for (int r = 0; r < 6; r++) begin
            int rl = $urandom_range(1, 5);
            int sk = (r % 2 == 0) ? $urandom_range(1, 150) : 200;
            do_run(rl, sk);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule